// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when a volatile SRAM image is copied into its nonvolatile shadow (a store) and when the shadow is copied back (a recall). A store can be requested in three ways. The first is an external active-low request pin, which is shared with the block's own busy indication. The second is a software command. The third is a supply-low flag from an analog comparator outside the block. A recall is pending after reset and after every supply-low episode, and it runs by itself once the supply is good again.

The block keeps a flag that records whether anything has been written since the last store or recall. Pin and power-loss stores are skipped when nothing has changed. It also gates the host's single-cycle SRAM port for the whole of each operation. The two arrays are modelled as copy engines: erase and program for a store, clear and load for a recall. Each phase lasts a parameterised number of clock cycles and takes effect on its last cycle.

Top module: `nvs_ctrl`

## Requirements
- R1: A granted host write marks the image modified. Completing any store or recall marks it unmodified. A store requested by the pin or by supply loss starts only when the image is modified; otherwise the busy drive stays low.
- R2: A software store (command code 2'b00 on `sw_cmd_i` with `sw_valid_i` high, accepted while idle) always runs. It asserts the busy drive for exactly ERASE_CYC+PROG_CYC cycles, beginning in the cycle after the command.
- R3: While the request pin reads low, host writes are refused and host reads are still granted. A store requested by the pin starts its busy drive GRACE_CYC+1 cycles after the first clock edge at which the pin is seen low.
- R4: While the busy drive is asserted, no host access is granted. After a store requested by the pin, host access stays refused until the pin reads high. Access returns one cycle after that.
- R5: With automatic store enabled and the image modified, a rising supply-low flag starts a store in the next cycle. No host access is granted while the flag is high.
- R6: After reset, and after the supply-low flag falls, a recall runs without being requested. Host access is granted again exactly 1+CLR_CYC+LOAD_CYC cycles after the triggering edge. A software recall (code 2'b01) restores access CLR_CYC+LOAD_CYC cycles after its accepting edge.
- R7: A recall replaces every SRAM word with the shadow contents and leaves the shadow unchanged, so two recalls in a row read back the same data.
- R8: A store, from any source, captures the SRAM contents present when its program phase ends.
- R9: Automatic store is enabled out of reset. Code 2'b10 disables it and code 2'b11 enables it again. While it is disabled, supply loss starts no store.
- R10: When several store requests are pending in the same idle cycle, supply loss wins over the pin, and the pin wins over a software command.
- R11: A software command issued while an operation is running is ignored.
- R12: During reset the busy drive is low and no host access is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| supply_low_i | input | 1 | Digital supply-low flag, 1 = supply below threshold |
| busy_pin_i | input | 1 | Sampled level of the shared active-low request/busy pin |
| busy_drive_o | output | 1 | Drive-low enable for the shared pin, 1 while a store runs |
| sw_valid_i | input | 1 | Software command strobe |
| sw_cmd_i | input | 2 | Software command code: 00 store, 01 recall, 10 automatic store off, 11 automatic store on |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host access is a write when 1 |
| host_addr_i | input | ADDR_W | Host word address |
| host_wdata_i | input | DATA_W | Host write data |
| host_gnt_o | output | 1 | Host access accepted in this cycle |
| host_rdata_o | output | DATA_W | Read data, updated one cycle after a granted read |

## Verification
The data path is tried with three arithmetic word patterns over every address. Each one is stored, then overwritten with its complement, then recalled, which separates a working store from one that leaves stale shadow data. Every trigger is run once with the image modified and once without: the software store, the pin request and the supply-low flag. This separates the dirty gating of the pin and power paths from the unconditional software store. Simultaneous pin, supply and command requests tell the priority order apart by whether busy starts at once or only after the grace window. A command issued mid-store and a store attempted with automatic store disabled are both judged by later pin and data behaviour.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GRACE,
        ST_PIN_HOLD,
        ST_ERASE,
        ST_PROG,
        ST_PIN_WAIT,
        ST_PWR_WAIT,
        ST_RCLR,
        ST_RLOAD
    } nvs_state_e;

    typedef enum logic [1:0] {
        CMD_STORE    = 2'b00,
        CMD_RECALL   = 2'b01,
        CMD_AUTO_OFF = 2'b10,
        CMD_AUTO_ON  = 2'b11
    } nvs_cmd_e;

    typedef enum logic [3:0] {
        DEC_NONE,
        DEC_PWR_STORE,
        DEC_PWR_WAIT,
        DEC_RECALL,
        DEC_PIN_STORE,
        DEC_PIN_HOLD,
        DEC_SW_STORE,
        DEC_AUTO_OFF,
        DEC_AUTO_ON
    } nvs_dec_e;

    typedef struct packed {
        logic clr_sram;
        logic load_sram;
        logic erase_nv;
        logic prog_nv;
    } nvs_xfer_t;

    function automatic logic is_store(nvs_state_e s);
        return (s == ST_ERASE) || (s == ST_PROG);
    endfunction

    function automatic logic reads_only(nvs_state_e s);
        return (s == ST_GRACE) || (s == ST_PIN_HOLD);
    endfunction

endpackage

// File: rtl/nvs_arb.sv
module nvs_arb
    import nvs_pkg::*;
(
    input  logic     supply_low,
    input  logic     recall_pend,
    input  logic     pin_low,
    input  logic     auto_en,
    input  logic     dirty,
    input  logic     sw_valid,
    input  nvs_cmd_e sw_cmd,
    output nvs_dec_e dec
);
    always_comb begin
        dec = DEC_NONE;
        if (supply_low) begin
            dec = (auto_en && dirty) ? DEC_PWR_STORE : DEC_PWR_WAIT;
        end else if (recall_pend) begin
            dec = DEC_RECALL;
        end else if (pin_low) begin
            dec = dirty ? DEC_PIN_STORE : DEC_PIN_HOLD;
        end else if (sw_valid) begin
            case (sw_cmd)
                CMD_STORE:    dec = DEC_SW_STORE;
                CMD_RECALL:   dec = DEC_RECALL;
                CMD_AUTO_OFF: dec = DEC_AUTO_OFF;
                default:      dec = DEC_AUTO_ON;
            endcase
        end
    end
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/nvs_store_array.sv
module nvs_store_array
    import nvs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  nvs_xfer_t         xfer,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sram_q [DEPTH];
    logic [DATA_W-1:0] nv_q   [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                sram_q[i] <= '0;
                nv_q[i]   <= '0;
            end else begin
                if (xfer.clr_sram) begin
                    sram_q[i] <= '0;
                end else if (xfer.load_sram) begin
                    sram_q[i] <= nv_q[i];
                end else if (wr_en && (addr == ADDR_W'(i))) begin
                    sram_q[i] <= wdata;
                end
                if (xfer.erase_nv) begin
                    nv_q[i] <= '0;
                end else if (xfer.prog_nv) begin
                    nv_q[i] <= sram_q[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sram_q[addr];
        end
    end
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
    import nvs_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 8,
    parameter int GRACE_CYC = 4,
    parameter int ERASE_CYC = 3,
    parameter int PROG_CYC  = 5,
    parameter int CLR_CYC   = 2,
    parameter int LOAD_CYC  = 4,
    localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_low_i,
    input  logic              busy_pin_i,
    output logic              busy_drive_o,
    input  logic              sw_valid_i,
    input  logic [1:0]        sw_cmd_i,
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              host_gnt_o,
    output logic [DATA_W-1:0] host_rdata_o
);
    localparam int MAX_A  = (GRACE_CYC > ERASE_CYC) ? GRACE_CYC : ERASE_CYC;
    localparam int MAX_B  = (PROG_CYC > CLR_CYC) ? PROG_CYC : CLR_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_D  = (MAX_C > LOAD_CYC) ? MAX_C : LOAD_CYC;
    localparam int CNT_W  = $clog2(MAX_D + 1);

    nvs_state_e       state_q, state_d;
    nvs_dec_e         dec;
    nvs_xfer_t        xfer;
    logic             dirty_q, auto_en_q, recall_pend_q, src_pin_q;
    logic             t_done, t_load;
    logic [CNT_W-1:0] t_val;
    logic             pin_low, open_q;

    assign pin_low = !busy_pin_i;
    assign open_q  = !supply_low_i && !recall_pend_q;

    nvs_arb u_arb (
        .supply_low (supply_low_i),
        .recall_pend(recall_pend_q),
        .pin_low    (pin_low),
        .auto_en    (auto_en_q),
        .dirty      (dirty_q),
        .sw_valid   (sw_valid_i),
        .sw_cmd     (nvs_cmd_e'(sw_cmd_i)),
        .dec        (dec)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                case (dec)
                    DEC_PWR_STORE, DEC_SW_STORE: state_d = ST_ERASE;
                    DEC_PWR_WAIT:                state_d = ST_PWR_WAIT;
                    DEC_RECALL:                  state_d = ST_RCLR;
                    DEC_PIN_STORE:               state_d = ST_GRACE;
                    DEC_PIN_HOLD:                state_d = ST_PIN_HOLD;
                    default:                     state_d = ST_IDLE;
                endcase
            end
            ST_GRACE: if (t_done) state_d = ST_ERASE;
            ST_ERASE: if (t_done) state_d = ST_PROG;
            ST_PROG:  if (t_done) state_d = src_pin_q ? ST_PIN_WAIT : ST_IDLE;
            ST_PIN_HOLD, ST_PIN_WAIT: begin
                if (supply_low_i || !pin_low) state_d = ST_IDLE;
            end
            ST_PWR_WAIT: if (!supply_low_i) state_d = ST_RCLR;
            ST_RCLR:  if (t_done) state_d = ST_RLOAD;
            ST_RLOAD: if (t_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign t_load = (state_d != state_q);
    always_comb begin
        case (state_d)
            ST_GRACE: t_val = CNT_W'(GRACE_CYC - 1);
            ST_ERASE: t_val = CNT_W'(ERASE_CYC - 1);
            ST_PROG:  t_val = CNT_W'(PROG_CYC - 1);
            ST_RCLR:  t_val = CNT_W'(CLR_CYC - 1);
            ST_RLOAD: t_val = CNT_W'(LOAD_CYC - 1);
            default:  t_val = '0;
        endcase
    end

    nvs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .load_val(t_val),
        .done    (t_done)
    );

    always_comb begin
        xfer.erase_nv  = (state_q == ST_ERASE) && t_done;
        xfer.prog_nv   = (state_q == ST_PROG)  && t_done;
        xfer.clr_sram  = (state_q == ST_RCLR)  && t_done;
        xfer.load_sram = (state_q == ST_RLOAD) && t_done;
    end

    always_comb begin
        if (state_q == ST_IDLE) begin
            host_gnt_o = host_req_i && open_q && !(host_we_i && pin_low);
        end else if (reads_only(state_q)) begin
            host_gnt_o = host_req_i && open_q && !host_we_i;
        end else begin
            host_gnt_o = 1'b0;
        end
    end

    assign busy_drive_o = is_store(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            dirty_q       <= 1'b0;
            auto_en_q     <= 1'b1;
            recall_pend_q <= 1'b1;
            src_pin_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (xfer.prog_nv || xfer.load_sram) begin
                dirty_q <= 1'b0;
            end else if (host_gnt_o && host_we_i) begin
                dirty_q <= 1'b1;
            end
            if (state_q == ST_IDLE && dec == DEC_AUTO_OFF) auto_en_q <= 1'b0;
            if (state_q == ST_IDLE && dec == DEC_AUTO_ON)  auto_en_q <= 1'b1;
            if (supply_low_i) begin
                recall_pend_q <= 1'b1;
            end else if (state_d == ST_RCLR && state_q != ST_RCLR) begin
                recall_pend_q <= 1'b0;
            end
            if (state_q == ST_IDLE && state_d == ST_GRACE) begin
                src_pin_q <= 1'b1;
            end else if (state_q == ST_IDLE && state_d == ST_ERASE) begin
                src_pin_q <= 1'b0;
            end
        end
    end

    nvs_store_array #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_array (
        .clk  (clk),
        .rst  (rst),
        .wr_en(host_gnt_o && host_we_i),
        .rd_en(host_gnt_o && !host_we_i),
        .addr (host_addr_i),
        .wdata(host_wdata_i),
        .xfer (xfer),
        .rdata(host_rdata_o)
    );
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic supply_low_i,
    input logic busy_pin_i,
    input logic busy_drive_o,
    input logic host_we_i,
    input logic host_gnt_o,
    input logic dirty_q
);
    // R1
    dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
        (host_gnt_o && host_we_i) |=> dirty_q);

    // R1
    dirty_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_drive_o) |-> !dirty_q);

    // R3
    pin_write_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_pin_i && host_we_i) |-> !host_gnt_o);

    // R4
    busy_no_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        busy_drive_o |-> !host_gnt_o);

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_drive_o) |=> busy_drive_o);

    // R5
    supply_low_block_chk: assert property (@(posedge clk) disable iff (rst)
        supply_low_i |-> !host_gnt_o);

    // R6
    recall_after_restore_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(supply_low_i) |=> !host_gnt_o);
endmodule

bind nvs_ctrl nvs_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .supply_low_i(supply_low_i),
    .busy_pin_i  (busy_pin_i),
    .busy_drive_o(busy_drive_o),
    .host_we_i   (host_we_i),
    .host_gnt_o  (host_gnt_o),
    .dirty_q     (dirty_q)
);

// File: tb/nvs_ctrl_tb.sv
module nvs_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8, DEPTH = 8, AW = 3;
    localparam int GRACE = 4, ERASE = 3, PROG = 5, CLR = 2, LOAD = 4;

    logic clk = 0, rst = 1;
    logic supply_low = 0, ext_low = 0, busy_drive;
    logic sw_valid = 0;
    logic [1:0] sw_cmd = 0;
    logic req = 0, we = 0;
    logic [AW-1:0] addr = 0;
    logic [DW-1:0] wdata = 0, rdata;
    logic gnt, busy_pin;

    int checks = 0, errors = 0;
    bit done_flag = 0;
    logic [DW-1:0] sram_m [DEPTH];
    logic [DW-1:0] nv_m   [DEPTH];

    assign busy_pin = !(ext_low || busy_drive);
    always #(CLK_PERIOD/2) clk = !clk;

    nvs_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .GRACE_CYC(GRACE), .ERASE_CYC(ERASE),
               .PROG_CYC(PROG), .CLR_CYC(CLR), .LOAD_CYC(LOAD)) dut_i (
        .clk(clk), .rst(rst), .supply_low_i(supply_low), .busy_pin_i(busy_pin),
        .busy_drive_o(busy_drive), .sw_valid_i(sw_valid), .sw_cmd_i(sw_cmd),
        .host_req_i(req), .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata),
        .host_gnt_o(gnt), .host_rdata_o(rdata));

    task automatic chk(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(int a, int d, output bit g);
        req = 1; we = 1; addr = AW'(a); wdata = DW'(d);
        #1 g = gnt;
        tick();
        req = 0; we = 0;
        if (g) sram_m[a] = DW'(d);
    endtask

    task automatic rd(int a, output int d, output bit g);
        req = 1; we = 0; addr = AW'(a);
        #1 g = gnt;
        tick();
        d = rdata; req = 0;
    endtask

    task automatic sw(logic [1:0] c);
        sw_valid = 1; sw_cmd = c;
        tick();
        sw_valid = 0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy_drive && n < 1000) begin n++; tick(); end
    endtask

    task automatic wait_gnt(output int n);
        req = 1; we = 0; addr = 0; n = 0;
        do begin tick(); n++; end while (!gnt && n < 1000);
        req = 0;
    endtask

    task automatic store_model();
        for (int i = 0; i < DEPTH; i++) nv_m[i] = sram_m[i];
    endtask

    task automatic recall_model();
        for (int i = 0; i < DEPTH; i++) sram_m[i] = nv_m[i];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, d;
        bit g;
        for (int i = 0; i < DEPTH; i++) begin sram_m[i] = 0; nv_m[i] = 0; end
        // R12 reset state
        req = 1; we = 0;
        repeat (3) tick();
        chk("R12 busy in reset", busy_drive, 0);
        chk("R12 gnt in reset", gnt, 0);
        req = 0;
        rst = 0;
        // R6 power-up recall
        wait_gnt(n);
        chk("R6 power-up recall cycles", n, 1 + CLR + LOAD);

        // R7 R8 R2 pattern sweep
        for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < DEPTH; a++) wr(a, (a * 37 + p * 91 + 5) & 8'hFF, g);
            sw(2'b00);
            count_busy(n);
            chk("R2 sw store busy length", n, ERASE + PROG);
            store_model();
            for (int a = 0; a < DEPTH; a++) wr(a, ~(a * 37 + p * 91 + 5) & 8'hFF, g);
            sw(2'b01);
            wait_gnt(n);
            chk("R6 sw recall cycles", n, CLR + LOAD);
            recall_model();
            for (int a = 0; a < DEPTH; a++) begin
                rd(a, d, g);
                chk("R8 R7 recalled word", d, nv_m[a]);
            end
        end
        sw(2'b01);
        wait_gnt(n);
        for (int a = 0; a < DEPTH; a += 3) begin
            rd(a, d, g);
            chk("R7 shadow unchanged by recall", d, nv_m[a]);
        end

        // R2 clean software store still runs
        sw(2'b00);
        chk("R2 clean sw store starts", busy_drive, 1);
        count_busy(n);
        chk("R2 clean sw store length", n, ERASE + PROG);

        // R3 R4 pin store with modified image
        wr(2, 8'h5A, g);
        ext_low = 1; req = 1; we = 1; addr = 2;
        #1 chk("R3 write refused on pin low", gnt, 0);
        we = 0;
        #1 chk("R3 read granted on pin low", gnt, 1);
        tick();
        n = 1;
        while (!busy_drive && n < 100) begin tick(); n++; end
        req = 0;
        chk("R3 grace before pin store", n, GRACE + 1);
        count_busy(n);
        chk("R4 pin store busy length", n, ERASE + PROG);
        store_model();
        req = 1;
        for (int k = 0; k < 5; k++) begin
            #1 chk("R4 held until pin high", gnt, 0);
            tick();
        end
        ext_low = 0;
        tick();
        chk("R4 access after pin high", gnt, 1);
        req = 0;
        wr(2, 8'h11, g);
        sw(2'b01); wait_gnt(n); recall_model();
        rd(2, d, g);
        chk("R8 pin store captured data", d, 8'h5A);

        // R1 R3 pin request with clean image
        ext_low = 1;
        n = 0;
        for (int k = 0; k < 20; k++) begin tick(); if (busy_drive) n++; end
        chk("R1 clean pin request no store", n, 0);
        req = 1; we = 0;
        #1 chk("R3 read during pin hold", gnt, 1);
        we = 1;
        #1 chk("R3 write during pin hold", gnt, 0);
        req = 0; we = 0;
        ext_low = 0; tick();

        // R5 power loss with modified image
        wr(0, 8'hA5, g);
        supply_low = 1; tick();
        chk("R5 power store starts next cycle", busy_drive, 1);
        count_busy(n);
        chk("R5 power store busy length", n, ERASE + PROG);
        store_model();
        req = 1;
        for (int k = 0; k < 5; k++) begin
            #1 chk("R5 access refused on low supply", gnt, 0);
            tick();
        end
        req = 0;
        supply_low = 0;
        wait_gnt(n);
        chk("R6 recall after supply restore", n, 1 + CLR + LOAD);
        recall_model();
        rd(0, d, g);
        chk("R8 power store captured data", d, 8'hA5);

        // R1 power loss with clean image
        supply_low = 1; n = 0;
        for (int k = 0; k < 10; k++) begin tick(); if (busy_drive) n++; end
        chk("R1 clean power loss no store", n, 0);
        supply_low = 0; wait_gnt(n);

        // R9 automatic store disabled and re-enabled
        sw(2'b10);
        wr(1, 8'h3C, g);
        supply_low = 1; n = 0;
        for (int k = 0; k < 10; k++) begin tick(); if (busy_drive) n++; end
        chk("R9 no store when disabled", n, 0);
        supply_low = 0; wait_gnt(n); recall_model();
        rd(1, d, g);
        chk("R9 shadow kept old word", d, nv_m[1]);
        sw(2'b11);
        wr(1, 8'h3C, g);
        supply_low = 1; tick();
        chk("R9 store after re-enable", busy_drive, 1);
        count_busy(n); store_model();
        supply_low = 0; wait_gnt(n); recall_model();

        // R10 supply loss beats pin and software
        wr(3, 8'h77, g);
        supply_low = 1; ext_low = 1; sw_valid = 1; sw_cmd = 2'b00;
        tick();
        sw_valid = 0;
        chk("R10 power wins immediately", busy_drive, 1);
        count_busy(n); store_model();
        repeat (3) tick();
        supply_low = 0; repeat (10) tick();
        ext_low = 0; tick(); recall_model();
        // R10 pin beats software
        wr(3, 8'h78, g);
        ext_low = 1; sw_valid = 1; sw_cmd = 2'b00;
        tick();
        sw_valid = 0;
        chk("R10 pin wins, grace first", busy_drive, 0);
        n = 1;
        while (!busy_drive && n < 100) begin tick(); n++; end
        chk("R10 pin grace length", n, GRACE + 1);
        count_busy(n); store_model();
        ext_low = 0; tick();

        // R11 command during store ignored
        sw(2'b00);
        tick();
        sw(2'b10);
        count_busy(n);
        wr(4, 8'h42, g);
        supply_low = 1; tick();
        chk("R11 mid-store command ignored", busy_drive, 1);
        count_busy(n);
        supply_low = 0; wait_gnt(n);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule